// File: doc/BRIEF.md
# Clock Alarm Hold, Sticky Flags and Alarm Pin Driver

This block follows four per-input clock monitors. Each monitor reports a raw loss-of-signal (LOS) fault and a raw frequency-offset (FOS) fault. A fault on an input latches that input's read-only LOS or FOS status bit. The bit stays set until the input has been fault-free for a validation window. The window is measured in pulses of a reference enable (`tick`), and a 2-bit selector picks its length. Any new fault on the same input holds the status and starts the window again from zero.

The held status drives four alarm pins. Pin n covers input n. A global enable decides whether FOS counts toward a pin or whether the pin follows LOS alone. One polarity bit sets the active level of the pins, and each pin has its own output enable. When a pin is disabled, its enable output is low and its data output is 0. Sticky flags capture every raw fault and are cleared by write-1 pulses. Per-flag masks decide which flags reach the active-high interrupt. When the interrupt-pin enable is set, the interrupt takes over the fourth pin.

All control inputs are plain level signals. All status outputs are registered. There is no streaming data path, so there is no handshake.

Top module: `clkalm_top`

## Requirements
- R1: A raw LOS (or FOS) fault on input n in one cycle sets `los_status[n]` (or `fos_status[n]`) at the next clock edge.
- R2: Alarm pin n represents `los_status[n]` when `fos_en`=0, and `los_status[n] | fos_status[n]` when `fos_en`=1. The pin takes this value one edge after the status bit changes.
- R3: While an input's status is held and no fault is present, each cycle with `tick`=1 advances a count. Both status bits clear at the edge of the Nth such tick. N is 256, 1024, 4096 or 16384 for `val_sel` = 0, 1, 2 or 3.
- R4: A LOS or FOS fault on an input while its window is running keeps the status set and restarts the count from zero.
- R5: Cycles with `tick`=0 do not advance the validation count.
- R6: A raw fault sets the matching sticky flag at the next edge. A 1 on the matching `*_clr` bit clears the flag. If a fault and a clear occur in the same cycle, the flag stays set.
- R7: `irq` is the OR of all flags whose mask bit is 0 (mask bit 1 = masked). It is registered one edge after the flags and is always active high.
- R8: When `active_low`=1, the alarm value on pins is inverted, so an asserted alarm reads 0.
- R9: `alarm_oe[n]` follows `pin_en[n]` one edge later. A pin whose enable output is 0 drives `alarm_out[n]`=0.
- R10: When `int_pin_en`=1, pin 4 (index 3) has `alarm_oe[3]`=1 and carries `irq`, active high, in the same cycle as `irq`. This holds whatever `pin_en[3]` is set to.
- R11: Reset clears all status bits, counters, flags, `irq`, alarm outputs and output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference enable pulse for validation timing |
| raw_los | input | 4 | Raw LOS fault per input |
| raw_fos | input | 4 | Raw FOS fault per input |
| val_sel | input | 2 | Validation window selector |
| fos_en | input | 1 | Let FOS status contribute to alarm pins |
| active_low | input | 1 | Invert alarm pin level |
| pin_en | input | 4 | Per-pin output enable |
| int_pin_en | input | 1 | Route interrupt onto pin 4 |
| los_mask | input | 4 | Mask LOS flags from interrupt |
| fos_mask | input | 4 | Mask FOS flags from interrupt |
| los_clr | input | 4 | Write-1 clear of LOS flags |
| fos_clr | input | 4 | Write-1 clear of FOS flags |
| los_status | output | 4 | Held LOS status |
| fos_status | output | 4 | Held FOS status |
| los_flag | output | 4 | Sticky LOS flags |
| fos_flag | output | 4 | Sticky FOS flags |
| irq | output | 1 | Interrupt, active high |
| alarm_out | output | 4 | Alarm pin data |
| alarm_oe | output | 4 | Alarm pin output enable (0 = tri-state) |

## Verification
A validation counter with a wrong value shows up as a status bit, and the alarm pin one edge later, falling too early or too late. That error becomes visible only at the end of a window, so a run must reach the exact terminal tick of each window length it checks, including windows that were restarted or paced by sparse ticks. A wrong flag or mask state appears on `irq` one edge after the flag. A wrong pin-routing state appears on `alarm_out` and `alarm_oe` at the next edge. The bench compares every output against a behavioural model on every cycle, so any such error is caught in the cycle it first reaches a port.

// File: rtl/clkalm_pkg.sv
package clkalm_pkg;
  localparam int unsigned NUM_IN = 4;
  typedef logic [NUM_IN-1:0] chan_vec_t;
  typedef enum logic [1:0] {
    VW_SHORT = 2'd0,
    VW_MED   = 2'd1,
    VW_LONG  = 2'd2,
    VW_MAX   = 2'd3
  } valwin_e;
endpackage

// File: rtl/clkalm_validator.sv
module clkalm_validator #(
  parameter int unsigned VAL_CNT0 = 256,
  parameter int unsigned VAL_CNT1 = 1024,
  parameter int unsigned VAL_CNT2 = 4096,
  parameter int unsigned VAL_CNT3 = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       los_in,
  input  logic       fos_in,
  input  logic [1:0] val_sel,
  output logic       los_hold,
  output logic       fos_hold
);
  import clkalm_pkg::*;
  // VAL_CNT3 is taken as the largest window
  localparam int unsigned CW = $clog2(VAL_CNT3);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          fault;
  logic          held;

  always_comb begin
    case (valwin_e'(val_sel))
      VW_SHORT: limit = CW'(VAL_CNT0 - 1);
      VW_MED:   limit = CW'(VAL_CNT1 - 1);
      VW_LONG:  limit = CW'(VAL_CNT2 - 1);
      default:  limit = CW'(VAL_CNT3 - 1);
    endcase
  end

  assign fault = los_in | fos_in;
  assign held  = los_hold | fos_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_hold <= 1'b0;
      fos_hold <= 1'b0;
      cnt_q    <= '0;
    end else if (fault) begin
      if (los_in) los_hold <= 1'b1;
      if (fos_in) fos_hold <= 1'b1;
      cnt_q <= '0;
    end else if (held && tick) begin
      if (cnt_q >= limit) begin
        los_hold <= 1'b0;
        fos_hold <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkalm_flags.sv
module clkalm_flags
  import clkalm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_vec_t los_set,
  input  chan_vec_t fos_set,
  input  chan_vec_t los_clr,
  input  chan_vec_t fos_clr,
  input  chan_vec_t los_mask,
  input  chan_vec_t fos_mask,
  output chan_vec_t los_flag,
  output chan_vec_t fos_flag,
  output logic      irq_next,
  output logic      irq
);
  assign irq_next = |((los_flag & ~los_mask) | (fos_flag & ~fos_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_flag <= '0;
      fos_flag <= '0;
      irq      <= 1'b0;
    end else begin
      los_flag <= (los_flag & ~los_clr) | los_set;
      fos_flag <= (fos_flag & ~fos_clr) | fos_set;
      irq      <= irq_next;
    end
  end
endmodule

// File: rtl/clkalm_pins.sv
module clkalm_pins
  import clkalm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_vec_t los_hold,
  input  chan_vec_t fos_hold,
  input  logic      fos_en,
  input  logic      active_low,
  input  chan_vec_t pin_en,
  input  logic      int_pin_en,
  input  logic      irq_next,
  output chan_vec_t alarm_out,
  output chan_vec_t alarm_oe
);
  localparam int unsigned TAKEOVER = NUM_IN - 1;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    logic alarm_lvl, drive, value;
    assign alarm_lvl = (los_hold[i] | (fos_en & fos_hold[i])) ^ active_low;
    if (i == TAKEOVER) begin : g_shared
      assign drive = pin_en[i] | int_pin_en;
      assign value = int_pin_en ? irq_next : alarm_lvl;
    end else begin : g_plain
      assign drive = pin_en[i];
      assign value = alarm_lvl;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_out[i] <= 1'b0;
        alarm_oe[i]  <= 1'b0;
      end else begin
        alarm_out[i] <= drive & value;
        alarm_oe[i]  <= drive;
      end
    end
  end
endmodule

// File: rtl/clkalm_top.sv
module clkalm_top #(
  parameter int unsigned VAL_CNT0 = 256,
  parameter int unsigned VAL_CNT1 = 1024,
  parameter int unsigned VAL_CNT2 = 4096,
  parameter int unsigned VAL_CNT3 = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] raw_los,
  input  logic [3:0] raw_fos,
  input  logic [1:0] val_sel,
  input  logic       fos_en,
  input  logic       active_low,
  input  logic [3:0] pin_en,
  input  logic       int_pin_en,
  input  logic [3:0] los_mask,
  input  logic [3:0] fos_mask,
  input  logic [3:0] los_clr,
  input  logic [3:0] fos_clr,
  output logic [3:0] los_status,
  output logic [3:0] fos_status,
  output logic [3:0] los_flag,
  output logic [3:0] fos_flag,
  output logic       irq,
  output logic [3:0] alarm_out,
  output logic [3:0] alarm_oe
);
  import clkalm_pkg::*;
  logic irq_next;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
    clkalm_validator #(
      .VAL_CNT0(VAL_CNT0), .VAL_CNT1(VAL_CNT1),
      .VAL_CNT2(VAL_CNT2), .VAL_CNT3(VAL_CNT3)
    ) val_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .los_in(raw_los[i]), .fos_in(raw_fos[i]), .val_sel(val_sel),
      .los_hold(los_status[i]), .fos_hold(fos_status[i])
    );
  end

  clkalm_flags flags_i (
    .clk(clk), .rst_n(rst_n),
    .los_set(raw_los), .fos_set(raw_fos),
    .los_clr(los_clr), .fos_clr(fos_clr),
    .los_mask(los_mask), .fos_mask(fos_mask),
    .los_flag(los_flag), .fos_flag(fos_flag),
    .irq_next(irq_next), .irq(irq)
  );

  clkalm_pins pins_i (
    .clk(clk), .rst_n(rst_n),
    .los_hold(los_status), .fos_hold(fos_status),
    .fos_en(fos_en), .active_low(active_low),
    .pin_en(pin_en), .int_pin_en(int_pin_en), .irq_next(irq_next),
    .alarm_out(alarm_out), .alarm_oe(alarm_oe)
  );
endmodule

// File: rtl/clkalm_chk.sv
module clkalm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] raw_los,
  input logic [3:0] raw_fos,
  input logic [3:0] pin_en,
  input logic       int_pin_en,
  input logic [3:0] los_clr,
  input logic [3:0] fos_clr,
  input logic [3:0] los_status,
  input logic [3:0] fos_status,
  input logic [3:0] los_flag,
  input logic [3:0] fos_flag,
  input logic       irq,
  input logic [3:0] alarm_out,
  input logic [3:0] alarm_oe
);
  for (genvar i = 0; i < 4; i++) begin : g_bit
    // R1
    los_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raw_los[i] |=> los_status[i]);
    // R1
    fos_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raw_fos[i] |=> fos_status[i]);
    // R4
    no_clear_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los_status[i]) |-> !$past(raw_los[i] | raw_fos[i]));
    // R6
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_los[i] && los_clr[i]) |=> los_flag[i]);
    // R6
    fos_flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_fos[i] && fos_clr[i]) |=> fos_flag[i]);
    // R9
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_oe[i] |-> !alarm_out[i]);
  end
  for (genvar i = 0; i < 3; i++) begin : g_en
    // R9
    pin_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_en[i] |=> alarm_oe[i]);
  end
  // R10
  takeover_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pin_en |=> (alarm_oe[3] && (alarm_out[3] == irq)));
  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((los_flag | fos_flag) != 4'd0));
endmodule

bind clkalm_top clkalm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .raw_los(raw_los), .raw_fos(raw_fos),
  .pin_en(pin_en), .int_pin_en(int_pin_en),
  .los_clr(los_clr), .fos_clr(fos_clr),
  .los_status(los_status), .fos_status(fos_status),
  .los_flag(los_flag), .fos_flag(fos_flag), .irq(irq),
  .alarm_out(alarm_out), .alarm_oe(alarm_oe)
);

// File: tb/clkalm_top_tb_top.sv
module clkalm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [3:0] raw_los = '0, raw_fos = '0;
  logic [1:0] val_sel = '0;
  logic fos_en = 1'b0, active_low = 1'b0, int_pin_en = 1'b0;
  logic [3:0] pin_en = 4'hF, los_mask = '0, fos_mask = '0;
  logic [3:0] los_clr = '0, fos_clr = '0;
  logic [3:0] los_status, fos_status, los_flag, fos_flag, alarm_out, alarm_oe;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkalm_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_los(raw_los), .raw_fos(raw_fos),
    .val_sel(val_sel), .fos_en(fos_en), .active_low(active_low), .pin_en(pin_en),
    .int_pin_en(int_pin_en), .los_mask(los_mask), .fos_mask(fos_mask),
    .los_clr(los_clr), .fos_clr(fos_clr), .los_status(los_status),
    .fos_status(fos_status), .los_flag(los_flag), .fos_flag(fos_flag),
    .irq(irq), .alarm_out(alarm_out), .alarm_oe(alarm_oe)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R11";

  // reference model state
  logic [3:0] m_los, m_fos, m_lflag, m_fflag, m_out, m_oe;
  logic m_irq;
  int m_cnt[4];
  logic [3:0] al;
  logic irq_d, drv;

  function automatic int win_len(logic [1:0] s);
    case (s)
      2'd0: return 256;
      2'd1: return 1024;
      2'd2: return 4096;
      default: return 16384;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_los = '0; m_fos = '0; m_lflag = '0; m_fflag = '0;
      m_out = '0; m_oe = '0; m_irq = 1'b0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else begin
      irq_d = |((m_lflag & ~los_mask) | (m_fflag & ~fos_mask));
      for (int i = 0; i < 4; i++) al[i] = (m_los[i] | (fos_en & m_fos[i])) ^ active_low;
      for (int i = 0; i < 4; i++) begin
        drv = pin_en[i] | ((i == 3) & int_pin_en);
        m_oe[i] = drv;
        m_out[i] = drv & (((i == 3) && int_pin_en) ? irq_d : al[i]);
      end
      m_irq = irq_d;
      m_lflag = (m_lflag & ~los_clr) | raw_los;
      m_fflag = (m_fflag & ~fos_clr) | raw_fos;
      for (int i = 0; i < 4; i++) begin
        if (raw_los[i] || raw_fos[i]) begin
          if (raw_los[i]) m_los[i] = 1'b1;
          if (raw_fos[i]) m_fos[i] = 1'b1;
          m_cnt[i] = 0;
        end else if ((m_los[i] || m_fos[i]) && tick) begin
          if (m_cnt[i] >= win_len(val_sel) - 1) begin
            m_los[i] = 1'b0; m_fos[i] = 1'b0; m_cnt[i] = 0;
          end else m_cnt[i]++;
        end
      end
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) at %0t: actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 los_status", los_status, m_los);
      check("R1 fos_status", fos_status, m_fos);
      check("R6 los_flag", los_flag, m_lflag);
      check("R6 fos_flag", fos_flag, m_fflag);
      check("R7 irq", {3'b0, irq}, {3'b0, m_irq});
      check("R2/R8 alarm_out", alarm_out, m_out);
      check("R9 alarm_oe", alarm_oe, m_oe);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [3:0] l, logic [3:0] f);
    @(negedge clk); raw_los = l; raw_fos = f;
    @(negedge clk); raw_los = '0; raw_fos = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    wait_cyc(3);
    // R11: outputs cleared while in reset
    check("R11 reset los_status", los_status, 4'h0);
    check("R11 reset flags", los_flag | fos_flag, 4'h0);
    check("R11 reset pins", alarm_out | alarm_oe, 4'h0);
    check("R11 reset irq", {3'b0, irq}, 4'h0);
    rst_n = 1'b1;
    wait_cyc(2);

    phase = "R3 short window";
    pulse(4'b0001, 4'b0000);
    wait_cyc(250);
    check("R3 held before terminal tick", los_status, 4'b0001);
    wait_cyc(10);
    check("R3 cleared after 256 ticks", los_status, 4'b0000);

    phase = "R2 fos gating";
    fos_en = 1'b0;
    pulse(4'b0000, 4'b0010);
    wait_cyc(5);
    check("R2 fos ignored on pin", alarm_out & 4'b0010, 4'b0000);
    fos_en = 1'b1;
    wait_cyc(3);
    check("R2 fos on pin when enabled", alarm_out & 4'b0010, 4'b0010);
    wait_cyc(300);

    phase = "R4 restart";
    pulse(4'b0100, 4'b0000);
    wait_cyc(200);
    pulse(4'b0000, 4'b0100);
    wait_cyc(200);
    check("R4 still held after restart", los_status | fos_status, 4'b0100);
    wait_cyc(100);

    phase = "R5 sparse tick";
    pulse(4'b1000, 4'b0000);
    for (int k = 0; k < 700; k++) begin
      @(negedge clk); tick = (k % 3 == 0);
    end
    tick = 1'b1;
    wait_cyc(300);

    phase = "R3 longer windows";
    val_sel = 2'd1; pulse(4'b0001, 4'b0000); wait_cyc(1100);
    val_sel = 2'd2; pulse(4'b0000, 4'b0010); wait_cyc(4200);
    val_sel = 2'd3; pulse(4'b0100, 4'b0000); wait_cyc(16500);
    val_sel = 2'd0;

    phase = "R6 flags";
    @(negedge clk); los_clr = 4'hF; fos_clr = 4'hF;
    @(negedge clk); los_clr = '0; fos_clr = '0;
    wait_cyc(2);
    check("R6 flags cleared", los_flag | fos_flag, 4'h0);
    @(negedge clk); raw_los = 4'b0010; los_clr = 4'b0010;
    @(negedge clk); raw_los = '0; los_clr = '0;
    check("R6 set wins over clear", los_flag, 4'b0010);
    wait_cyc(300);

    phase = "R7 masks";
    los_mask = 4'hF; fos_mask = 4'hF;
    wait_cyc(3);
    check("R7 irq masked", {3'b0, irq}, 4'h0);
    los_mask = 4'b1101; wait_cyc(3);
    pulse(4'b0000, 4'b1000); wait_cyc(3);
    fos_mask = 4'b0111; wait_cyc(3);
    los_mask = '0; fos_mask = '0;
    @(negedge clk); los_clr = 4'hF; fos_clr = 4'hF;
    @(negedge clk); los_clr = '0; fos_clr = '0;
    wait_cyc(300);

    phase = "R8 polarity";
    active_low = 1'b1;
    wait_cyc(3);
    check("R8 idle pins high", alarm_out, 4'hF);
    pulse(4'b0101, 4'b0000); wait_cyc(300);
    active_low = 1'b0;

    phase = "R9 pin enable";
    pin_en = 4'b0101; pulse(4'b1111, 4'b0000); wait_cyc(4);
    check("R9 disabled pins low", alarm_out & 4'b1010, 4'h0);
    pin_en = 4'b0000; wait_cyc(3);
    pin_en = 4'hF; wait_cyc(300);

    phase = "R10 takeover";
    pin_en = 4'b0000; int_pin_en = 1'b1;
    wait_cyc(3);
    pulse(4'b0001, 4'b0000); wait_cyc(4);
    check("R10 pin4 carries irq", {alarm_oe[3], alarm_out[3]}, 2'b11);
    @(negedge clk); los_clr = 4'hF; fos_clr = 4'hF;
    @(negedge clk); los_clr = '0; fos_clr = '0;
    wait_cyc(3);
    pin_en = 4'hF; wait_cyc(300);
    int_pin_en = 1'b0;

    phase = "R2 random";
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        raw_los[b] = ($urandom_range(0, 299) == 0);
        raw_fos[b] = ($urandom_range(0, 299) == 0);
      end
      tick = ($urandom_range(0, 3) != 0);
      los_clr = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0;
      fos_clr = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 199) == 0) begin
        fos_en = 1'($urandom); active_low = 1'($urandom);
        int_pin_en = 1'($urandom); pin_en = 4'($urandom);
        los_mask = 4'($urandom); fos_mask = 4'($urandom);
      end
    end
    raw_los = '0; raw_fos = '0; los_clr = '0; fos_clr = '0;

    phase = "R11 reset again";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 status after reset", los_status | fos_status, 4'h0);
    check("R11 pins after reset", alarm_out | alarm_oe, 4'h0);
    rst_n = 1'b1;
    wait_cyc(5);
    finish_run();
  end
endmodule